// File: doc/BRIEF.md
# Dual-Mode Coprocessor Debug Scan Chain

This block is the target side of a 40-bit test data register through which an external debugger reaches a bank of coprocessor registers. The debugger shifts a command word in serially. On the update step the block does one of two things, chosen by the lowest bit of the word.

In direct mode it reads or writes one register of the bank. A direct read takes two passes. The first pass names the register. The next pass captures the register's value into the data field and shifts it out.

In execute mode the block latches the 32-bit instruction word and raises a one-cycle request to an external executor. Execute mode is accepted only while an enable bit inside the bank is set, and that bit can only be set by a direct write.

The TAP controller is not part of this block. It supplies the select, capture, shift and update enables. The bank decodes 64 addresses, of which the first `NUM_REGS` are backed by storage.

Top module: `cop_scan_chain`

## Requirements
- R1: After reset, tdo and exec_req are 0, exec_insn is 0, and every implemented register reads back as 0.
- R2: While selected, each shift_dr cycle moves tdi into bit 39 and shifts the chain toward bit 0. tdo shows bit 0, so a 40-bit word shifted in reappears at tdo, bit 0 first, during the next 40 shifts when there is no capture or update in between.
- R3: Word layout: bit 0 is the mode (1 = direct, 0 = execute), bits 32..1 are data or instruction (bit 1 = LSB), bits 38..33 are the register address (bit 33 = LSB), and bit 39 is the direction (1 = write, 0 = read).
- R4: On update_dr with a direct write word, the addressed implemented register takes the data field.
- R5: On update_dr with a direct read word, the addressed register value is held. The next capture_dr puts it into bits 32..1, where it is shifted out. A read does not alter the register.
- R6: Addresses at or above NUM_REGS (default 16) are unimplemented. Writes to them are ignored and reads from them return 0.
- R7: On update_dr with an execute word while enabled, exec_insn takes the instruction field and exec_req is 1 for exactly the one cycle after the update edge.
- R8: An execute word while disabled produces no exec_req, leaves exec_insn unchanged and writes no register.
- R9: Execute mode is enabled by bit 0 of register TEST_REG (default 15), which is written and read like any other register.
- R10: While intest_sel is 0, capture, shift and update have no effect and tdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| intest_sel | input | 1 | The instruction that selects this chain is active |
| capture_dr | input | 1 | Capture step enable |
| shift_dr | input | 1 | Shift step enable |
| update_dr | input | 1 | Update step enable |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| exec_req | output | 1 | One-cycle request to the instruction executor |
| exec_insn | output | 32 | Latched instruction word |

## Verification
A chain bit held in the wrong place shows at tdo within at most 40 shifts. In the bench that appears as a misplaced read-back field or a corrupted loop-through word on the very next pass. A bank or read-hold fault is only visible one pass later, when the capture loads the data field, so every write is followed by a separate read-back pass. A wrong enable bit or a wrong mode decode shows in the cycle right after the update edge, as a missing, spurious or stretched exec_req, or as an exec_insn that moved.

// File: rtl/cop_scan_pkg.sv
`timescale 1ns/1ps
package cop_scan_pkg;
    localparam int CHAIN_W = 40;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int DATA_LSB = 1;

    // Packed so that field positions equal chain bit positions.
    typedef struct packed {
        logic              wr;    // bit 39
        logic [ADDR_W-1:0] addr;  // bits 38..33
        logic [DATA_W-1:0] data;  // bits 32..1
        logic              phys;  // bit 0
    } cmd_t;
endpackage

// File: rtl/cop_shift_chain.sv
`timescale 1ns/1ps
module cop_shift_chain
    import cop_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               tdi,
    input  logic [DATA_W-1:0]  load_val,
    output logic [CHAIN_W-1:0] chain_q
);
    typedef struct packed {
        logic [CHAIN_W-1:0] sr;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_en) begin
            st_d.sr[DATA_LSB +: DATA_W] = load_val;
        end else if (shift_en) begin
            st_d.sr = {tdi, st_q.sr[CHAIN_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain_q = st_q.sr;
endmodule

// File: rtl/cop_reg_bank.sv
`timescale 1ns/1ps
module cop_reg_bank
    import cop_scan_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int TEST_REG = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              interp_en
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_REGS-1:0] hit;

    // One address comparator per implemented register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g] = (addr == ADDR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && hit[i]) st_d.regs[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [IDX_W-1:0] idx;
    assign idx       = addr[IDX_W-1:0];
    assign rdata     = (|hit) ? st_q.regs[idx] : '0;
    assign interp_en = st_q.regs[TEST_REG][0];
endmodule

// File: rtl/cop_exec_port.sv
`timescale 1ns/1ps
module cop_exec_port
    import cop_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] insn_in,
    output logic              exec_req,
    output logic [DATA_W-1:0] exec_insn
);
    typedef struct packed {
        logic              req;
        logic [DATA_W-1:0] insn;
    } exec_st_t;

    exec_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = fire;
        if (fire) st_d.insn = insn_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exec_req  = st_q.req;
    assign exec_insn = st_q.insn;
endmodule

// File: rtl/cop_scan_chain.sv
`timescale 1ns/1ps
module cop_scan_chain
    import cop_scan_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int TEST_REG = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        intest_sel,
    input  logic        capture_dr,
    input  logic        shift_dr,
    input  logic        update_dr,
    input  logic        tdi,
    output logic        tdo,
    output logic        exec_req,
    output logic [31:0] exec_insn
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CHAIN_W-1:0] chain_q;
    cmd_t               cmd;
    logic               cap_en, sh_en, upd_en;
    logic               bank_wr, interp_en, fire;
    logic [DATA_W-1:0]  bank_rdata;

    assign cap_en = intest_sel & capture_dr;
    assign sh_en  = intest_sel & shift_dr;
    assign upd_en = intest_sel & update_dr;
    assign cmd    = cmd_t'(chain_q);

    assign bank_wr = upd_en &  cmd.phys & cmd.wr;
    assign fire    = upd_en & ~cmd.phys & interp_en;

    always_comb begin
        st_d = st_q;
        if (upd_en && cmd.phys && !cmd.wr) st_d.hold = bank_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cop_shift_chain i_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (cap_en),
        .shift_en   (sh_en),
        .tdi        (tdi),
        .load_val   (st_q.hold),
        .chain_q    (chain_q)
    );

    cop_reg_bank #(.NUM_REGS(NUM_REGS), .TEST_REG(TEST_REG)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr),
        .addr      (cmd.addr),
        .wdata     (cmd.data),
        .rdata     (bank_rdata),
        .interp_en (interp_en)
    );

    cop_exec_port i_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .insn_in   (cmd.data),
        .exec_req  (exec_req),
        .exec_insn (exec_insn)
    );

    assign tdo = intest_sel ? chain_q[0] : 1'b0;
endmodule

// File: rtl/cop_scan_chain_chk.sv
`timescale 1ns/1ps
module cop_scan_chain_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        intest_sel,
    input logic        update_dr,
    input logic        exec_req,
    input logic [31:0] exec_insn
);
    // R1: idle request right after reset release
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !exec_req);

    // R7: request lasts exactly one cycle
    a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |=> !exec_req);

    // R7: request only follows a selected update
    a_r7_req_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> $past(update_dr && intest_sel));

    // R8: instruction output moves only with a request
    a_r8_insn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_req |-> $stable(exec_insn));

    // R10: no request when the chain was not selected
    a_r10_no_req_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(intest_sel) |-> !exec_req);
endmodule

bind cop_scan_chain cop_scan_chain_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .intest_sel (intest_sel),
    .update_dr  (update_dr),
    .exec_req   (exec_req),
    .exec_insn  (exec_insn)
);

// File: tb/test_cop_scan_chain.sv
`timescale 1ns/1ps
module test_cop_scan_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        intest_sel = 1'b1;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        exec_req;
    logic [31:0] exec_insn;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cop_scan_chain i_cop_scan_chain (
        .clk(clk), .rst_n(rst_n), .intest_sel(intest_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .exec_req(exec_req), .exec_insn(exec_insn)
    );

    // Vector: {is_write, addr[5:0], data[31:0], expected[31:0]}
    localparam int NV = 10;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 6'd1,  32'hA5A5_0001, 32'h0},
        {1'b1, 6'd2,  32'h1234_5678, 32'h0},
        {1'b1, 6'd14, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 6'd40, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 6'd1,  32'h0,         32'hA5A5_0001},
        {1'b0, 6'd2,  32'h0,         32'h1234_5678},
        {1'b0, 6'd14, 32'h0,         32'hFFFF_FFFF},
        {1'b0, 6'd40, 32'h0,         32'h0},
        {1'b1, 6'd2,  32'h0000_00FF, 32'h0},
        {1'b0, 6'd2,  32'h0,         32'h0000_00FF}
    };

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] mk(input logic wr, input logic [5:0] a,
                                       input logic [31:0] d, input logic phys);
        return {wr, a, d, phys};
    endfunction

    task automatic do_pass(input logic [39:0] w, input logic cap, input logic upd,
                           output logic [39:0] o);
        @(negedge clk); capture_dr = cap;
        @(negedge clk); capture_dr = 1'b0;
        for (int i = 0; i < 40; i++) begin
            shift_dr = 1'b1; tdi = w[i]; o[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = upd;
        @(negedge clk); update_dr = 1'b0;
    endtask

    task automatic phys_write(input logic [5:0] a, input logic [31:0] d);
        logic [39:0] o;
        do_pass(mk(1'b1, a, d, 1'b1), 1'b0, 1'b1, o);
    endtask

    task automatic phys_read(input logic [5:0] a, output logic [31:0] v);
        logic [39:0] o;
        do_pass(mk(1'b0, a, 32'h0, 1'b1), 1'b0, 1'b1, o);
        do_pass(40'h0, 1'b1, 1'b0, o);
        v = o[32:1];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [39:0] o1, o2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tdo", {39'h0, tdo}, 40'h0);
        chk("R1 exec_req", {39'h0, exec_req}, 40'h0);
        chk("R1 exec_insn", {8'h0, exec_insn}, 40'h0);
        phys_read(6'd3, v);  chk("R1 reg3", {8'h0, v}, 40'h0);
        phys_read(6'd15, v); chk("R1 reg15", {8'h0, v}, 40'h0);

        // R2 loop-through of 40 bits
        do_pass(40'hC3_5A0F_E172, 1'b0, 1'b0, o1);
        do_pass(40'h0, 1'b0, 1'b0, o2);
        chk("R2 loop-through", o2, 40'hC3_5A0F_E172);

        // R4 R5 R6 table walk (R3 layout used by mk)
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][70]) begin
                phys_write(VEC[k][69:64], VEC[k][63:32]);
            end else begin
                phys_read(VEC[k][69:64], v);
                chk((VEC[k][69:64] >= 6'd16) ? "R6 unimplemented read" : "R5 read-back",
                    {8'h0, v}, {8'h0, VEC[k][31:0]});
            end
        end
        phys_read(6'd63, v); chk("R6 top address", {8'h0, v}, 40'h0);
        phys_read(6'd1, v);  chk("R5 read not destructive", {8'h0, v}, 40'h00A5A50001);

        // R9 R7 execute mode while enabled
        phys_write(6'd15, 32'h1);
        phys_read(6'd15, v); chk("R9 enable reads back", {8'h0, v}, 40'h1);
        do_pass(mk(1'b0, 6'd7, 32'hE12F_FF1E, 1'b0), 1'b0, 1'b1, o1);
        chk("R7 exec_req pulse", {39'h0, exec_req}, 40'h1);
        chk("R7 exec_insn", {8'h0, exec_insn}, 40'h00E12FFF1E);
        @(negedge clk);
        chk("R7 pulse ends", {39'h0, exec_req}, 40'h0);

        // R8 execute mode while disabled
        phys_write(6'd15, 32'h0);
        phys_read(6'd15, v); chk("R9 disable reads back", {8'h0, v}, 40'h0);
        do_pass(mk(1'b1, 6'd5, 32'hCAFE_F00D, 1'b0), 1'b0, 1'b1, o1);
        chk("R8 no exec_req", {39'h0, exec_req}, 40'h0);
        chk("R8 exec_insn held", {8'h0, exec_insn}, 40'h00E12FFF1E);
        phys_read(6'd5, v); chk("R8 no register write", {8'h0, v}, 40'h0);

        // R10 deselected chain is inert
        intest_sel = 1'b0;
        do_pass(mk(1'b1, 6'd2, 32'h5555_5555, 1'b1), 1'b1, 1'b1, o1);
        chk("R10 tdo quiet", o1, 40'h0);
        intest_sel = 1'b1;
        phys_read(6'd2, v); chk("R10 register untouched", {8'h0, v}, 40'h00000000FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule